// File: doc/BRIEF.md
# Gap-Count and Root-Holdoff Register Controller

This block holds the gap-count and root-holdoff state of a serial-bus physical-layer node and follows the bus resets the node goes through. The link reaches it through a small host register port. Register 1 carries the root-holdoff bit, an initiate-long-reset bit and the 6-bit gap count. Register 5 carries an initiate-short-reset bit next to other control bits that the host owns.

A configuration-packet event input reports each PHY configuration packet, whether this node sent it or received it. Each such packet carries a root-holdoff value and a gap-count value. A bus-reset-complete pulse tells the block that a reset has finished.

The gap count falls back to its maximum only after two completed resets in a row with no update between them. An update is a register-1 write or a configuration packet. This lets software send a configuration packet, issue one confirming reset, and keep the new gap count.

Top module: `phy_gap_ctrl`

## Requirements
- R1: After the asynchronous reset, the gap count is 63, the root-holdoff bit is 0, both request strobes are 0, the consecutive-reset flag is clear, and register 5 reads 0.
- R2: A host write to address 1 loads the root-holdoff bit from data bit 7 and the gap count from data bits 5:0, visible on the outputs one cycle later. Reading address 1 returns {root_holdoff, 1'b0, gap[5:0]}.
- R3: A write to address 1 with data bit 6 set raises long_reset_req_o for exactly one cycle, in the cycle after the write. The same write also loads the root-holdoff bit and the gap count. Bit 6 always reads as 0.
- R4: A write to address 5 with data bit 1 set raises short_reset_req_o for exactly one cycle, in the cycle after the write. Bit 1 reads back as 0, and every other bit of address 5 reads back exactly as written.
- R5: A configuration packet event (cfg_pkt_i high) loads the root-holdoff bit and the gap count from cfg_rhb_i and cfg_gap_i. A single input serves packets that were sent and packets that were received.
- R6: The first bus-reset-complete pulse after an update leaves the gap count unchanged. A second pulse with no update in between forces the gap count to 63.
- R7: A register-1 write or a configuration packet clears the consecutive-reset tracking. The reset that follows a long-reset write therefore keeps the gap count that was just written.
- R8: When a configuration packet and a register-1 write fall in the same cycle, the packet's values are loaded. A long-reset strobe requested by that write is still issued.
- R9: When an update and a bus-reset-complete pulse fall in the same cycle, the update is loaded and the tracking ends up clear. The next pulse therefore does not force 63.
- R10: Writes to addresses other than 1 and 5 change neither the gap count nor the root-holdoff bit, and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host register write enable |
| reg_addr_i | input | 4 | Host register address, for both writes and reads |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| cfg_pkt_i | input | 1 | Configuration packet sent or received, one-cycle pulse |
| cfg_rhb_i | input | 1 | Root-holdoff field of the packet |
| cfg_gap_i | input | 6 | Gap-count field of the packet |
| bus_reset_done_i | input | 1 | Bus reset completed, one-cycle pulse |
| gap_count_o | output | 6 | Current gap count |
| root_holdoff_o | output | 1 | Current root-holdoff bit |
| long_reset_req_o | output | 1 | Long bus reset request strobe |
| short_reset_req_o | output | 1 | Short bus reset request strobe |

## Verification
Two pairs of events can land in the same cycle. A configuration packet can arrive with a register-1 write, and an update (packet or write) can arrive with a bus-reset-complete pulse. The vector table drives each pair in one cycle. For the first pair, the bench checks that the packet's gap count and root-holdoff bit win while the long-reset strobe still fires. For the second pair, the bench follows with a single further reset pulse and judges from the gap count that the tracking was left clear, since a forced 63 would reveal a stale flag.

// File: rtl/phy_gap_pkg.sv
package phy_gap_pkg;
  localparam int unsigned GAP_W   = 6;
  localparam int unsigned GAP_MAX = (1 << GAP_W) - 1;

  typedef struct packed {
    logic             valid;
    logic             rhb;
    logic [GAP_W-1:0] gap;
  } gap_upd_t;
endpackage

// File: rtl/phy_gap_host.sv
module phy_gap_host
  import phy_gap_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned LONG_ADDR  = 1,
  parameter int unsigned SHORT_ADDR = 5,
  parameter int unsigned ISBR_BIT   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rhb_i,
  input  logic [GAP_W-1:0]  gap_i,
  output logic [DATA_W-1:0] rdata_o,
  output gap_upd_t          upd_o,
  output logic              long_req_o,
  output logic              short_req_o
);
  localparam int unsigned IBR_BIT = GAP_W;
  localparam int unsigned RHB_BIT = GAP_W + 1;
  localparam logic [DATA_W-1:0] ISBR_MASK = DATA_W'(1) << ISBR_BIT;

  logic              sel_long, sel_short;
  logic [DATA_W-1:0] ctl5_q;

  assign sel_long  = we_i && (addr_i == ADDR_W'(LONG_ADDR));
  assign sel_short = we_i && (addr_i == ADDR_W'(SHORT_ADDR));

  assign upd_o.valid = sel_long;
  assign upd_o.rhb   = wdata_i[RHB_BIT];
  assign upd_o.gap   = wdata_i[GAP_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl5_q      <= '0;
      long_req_o  <= 1'b0;
      short_req_o <= 1'b0;
    end else begin
      long_req_o  <= sel_long && wdata_i[IBR_BIT];
      short_req_o <= sel_short && wdata_i[ISBR_BIT];
      if (sel_short) ctl5_q <= wdata_i & ~ISBR_MASK;  // self-clearing bit never stored
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(LONG_ADDR)) begin
      rdata_o[RHB_BIT]     = rhb_i;
      rdata_o[GAP_W-1:0]   = gap_i;
    end else if (addr_i == ADDR_W'(SHORT_ADDR)) begin
      rdata_o = ctl5_q;
    end
  end
endmodule

// File: rtl/phy_gap_track.sv
module phy_gap_track
  import phy_gap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  gap_upd_t         host_upd_i,
  input  gap_upd_t         pkt_upd_i,
  input  logic             reset_done_i,
  output logic [GAP_W-1:0] gap_o,
  output logic             rhb_o,
  output logic             armed_o
);
  gap_upd_t sel;
  logic     upd;

  // packet beats a simultaneous host write
  assign sel = pkt_upd_i.valid ? pkt_upd_i : host_upd_i;
  assign upd = pkt_upd_i.valid | host_upd_i.valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_o   <= GAP_W'(GAP_MAX);
      rhb_o   <= 1'b0;
      armed_o <= 1'b0;
    end else if (upd) begin
      gap_o   <= sel.gap;
      rhb_o   <= sel.rhb;
      armed_o <= 1'b0;  // same-cycle reset is absorbed by the update
    end else if (reset_done_i) begin
      if (armed_o) gap_o <= GAP_W'(GAP_MAX);
      armed_o <= 1'b1;
    end
  end
endmodule

// File: rtl/phy_gap_ctrl.sv
module phy_gap_ctrl
  import phy_gap_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned LONG_ADDR  = 1,
  parameter int unsigned SHORT_ADDR = 5,
  parameter int unsigned ISBR_BIT   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              cfg_pkt_i,
  input  logic              cfg_rhb_i,
  input  logic [GAP_W-1:0]  cfg_gap_i,
  input  logic              bus_reset_done_i,
  output logic [GAP_W-1:0]  gap_count_o,
  output logic              root_holdoff_o,
  output logic              long_reset_req_o,
  output logic              short_reset_req_o
);
  gap_upd_t host_upd, pkt_upd;
  logic     trk_armed;

  assign pkt_upd.valid = cfg_pkt_i;
  assign pkt_upd.rhb   = cfg_rhb_i;
  assign pkt_upd.gap   = cfg_gap_i;

  phy_gap_host #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LONG_ADDR(LONG_ADDR),
    .SHORT_ADDR(SHORT_ADDR), .ISBR_BIT(ISBR_BIT)
  ) u_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rhb_i       (root_holdoff_o),
    .gap_i       (gap_count_o),
    .rdata_o     (reg_rdata_o),
    .upd_o       (host_upd),
    .long_req_o  (long_reset_req_o),
    .short_req_o (short_reset_req_o)
  );

  phy_gap_track u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_upd_i   (host_upd),
    .pkt_upd_i    (pkt_upd),
    .reset_done_i (bus_reset_done_i),
    .gap_o        (gap_count_o),
    .rhb_o        (root_holdoff_o),
    .armed_o      (trk_armed)
  );
endmodule

// File: rtl/phy_gap_ctrl_chk.sv
module phy_gap_ctrl_chk
  import phy_gap_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned LONG_ADDR  = 1,
  parameter int unsigned SHORT_ADDR = 5,
  parameter int unsigned ISBR_BIT   = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              cfg_pkt_i,
  input logic              cfg_rhb_i,
  input logic [GAP_W-1:0]  cfg_gap_i,
  input logic              bus_reset_done_i,
  input logic [GAP_W-1:0]  gap_count_o,
  input logic              root_holdoff_o,
  input logic              long_reset_req_o,
  input logic              short_reset_req_o,
  input logic              trk_armed
);
  logic wr1, wr5, ibr, isbr;
  assign wr1  = reg_we_i && (reg_addr_i == ADDR_W'(LONG_ADDR));
  assign wr5  = reg_we_i && (reg_addr_i == ADDR_W'(SHORT_ADDR));
  assign ibr  = wr1 && reg_wdata_i[GAP_W];
  assign isbr = wr5 && reg_wdata_i[ISBR_BIT];

  AST_HOST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr1 && !cfg_pkt_i |=> gap_count_o == $past(reg_wdata_i[GAP_W-1:0])
                        && root_holdoff_o == $past(reg_wdata_i[GAP_W+1])); // R2
  AST_LONG_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibr |=> long_reset_req_o); // R3
  AST_LONG_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ibr |=> !long_reset_req_o); // R3
  AST_SHORT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isbr |=> short_reset_req_o); // R4
  AST_SHORT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !isbr |=> !short_reset_req_o); // R4
  AST_PKT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_pkt_i |=> gap_count_o == $past(cfg_gap_i)
               && root_holdoff_o == $past(cfg_rhb_i)); // R5
  AST_SECOND_RESET_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_done_i && trk_armed && !cfg_pkt_i && !wr1
      |=> gap_count_o == GAP_W'(GAP_MAX)); // R6
  AST_FIRST_RESET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_done_i && !trk_armed && !cfg_pkt_i && !wr1
      |=> $stable(gap_count_o) && $stable(root_holdoff_o) && trk_armed); // R6
  AST_UPDATE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_pkt_i || wr1 |=> !trk_armed); // R7
endmodule

bind phy_gap_ctrl phy_gap_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LONG_ADDR(LONG_ADDR),
  .SHORT_ADDR(SHORT_ADDR), .ISBR_BIT(ISBR_BIT)
) u_chk (.*);

// File: tb/phy_gap_ctrl_tb.sv
module phy_gap_ctrl_tb;
  typedef struct packed {
    logic       we;
    logic [3:0] addr;
    logic [7:0] wdata;
    logic       pkt;
    logic       prhb;
    logic [5:0] pgap;
    logic       rdone;
    logic [5:0] egap;
    logic       erhb;
    logic       elong;
    logic       eshort;
  } vec_t;

  localparam int NV = 19;
  // we addr wdata pkt prhb pgap rdone | egap erhb elong eshort
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 6'd0,  1'b0, 6'd63, 1'b0, 1'b0, 1'b0}, // idle           R1
    '{1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 6'd0,  1'b1, 6'd63, 1'b0, 1'b0, 1'b0}, // reset, arms    R6
    '{1'b1, 4'd1, 8'h8A, 1'b0, 1'b0, 6'd0,  1'b0, 6'd10, 1'b1, 1'b0, 1'b0}, // host reg1      R2
    '{1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 6'd0,  1'b1, 6'd10, 1'b1, 1'b0, 1'b0}, // 1st reset      R6
    '{1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 6'd0,  1'b1, 6'd63, 1'b1, 1'b0, 1'b0}, // 2nd reset      R6
    '{1'b0, 4'd0, 8'h00, 1'b1, 1'b0, 6'd20, 1'b0, 6'd20, 1'b0, 1'b0, 1'b0}, // packet         R5
    '{1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 6'd0,  1'b1, 6'd20, 1'b0, 1'b0, 1'b0}, // reset, arms    R6
    '{1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 6'd5,  1'b0, 6'd5,  1'b1, 1'b0, 1'b0}, // packet clears  R7
    '{1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 6'd0,  1'b1, 6'd5,  1'b1, 1'b0, 1'b0}, // reset kept     R7
    '{1'b1, 4'd1, 8'h4C, 1'b0, 1'b0, 6'd0,  1'b0, 6'd12, 1'b0, 1'b1, 1'b0}, // long write     R3
    '{1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 6'd0,  1'b1, 6'd12, 1'b0, 1'b0, 1'b0}, // reset keeps    R7
    '{1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 6'd0,  1'b0, 6'd12, 1'b0, 1'b0, 1'b0}, // idle           R3
    '{1'b1, 4'd5, 8'hA6, 1'b0, 1'b0, 6'd0,  1'b0, 6'd12, 1'b0, 1'b0, 1'b1}, // short write    R4
    '{1'b1, 4'd1, 8'h41, 1'b1, 1'b1, 6'd30, 1'b0, 6'd30, 1'b1, 1'b1, 1'b0}, // pkt+write      R8
    '{1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 6'd0,  1'b1, 6'd30, 1'b1, 1'b0, 1'b0}, // reset arms     R8
    '{1'b0, 4'd0, 8'h00, 1'b1, 1'b0, 6'd7,  1'b1, 6'd7,  1'b0, 1'b0, 1'b0}, // pkt+reset      R9
    '{1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 6'd0,  1'b1, 6'd7,  1'b0, 1'b0, 1'b0}, // not forced     R9
    '{1'b1, 4'd3, 8'hFF, 1'b0, 1'b0, 6'd0,  1'b0, 6'd7,  1'b0, 1'b0, 1'b0}, // other addr     R10
    '{1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 6'd0,  1'b1, 6'd63, 1'b0, 1'b0, 1'b0}  // forced         R10
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [3:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       cfg_pkt_i = 1'b0;
  logic       cfg_rhb_i = 1'b0;
  logic [5:0] cfg_gap_i = '0;
  logic       bus_reset_done_i = 1'b0;
  logic [5:0] gap_count_o;
  logic       root_holdoff_o;
  logic       long_reset_req_o;
  logic       short_reset_req_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  phy_gap_ctrl u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_reset_state();
    reg_addr_i = 4'd5;
    #1;
    chk("R1 gap", gap_count_o, 63);
    chk("R1 rhb", root_holdoff_o, 0);
    chk("R1 long", long_reset_req_o, 0);
    chk("R1 short", short_reset_req_o, 0);
    chk("R1 reg5", reg_rdata_o, 0);
    reg_addr_i = 4'd0;
  endtask

  initial begin
    #23;
    check_reset_state();
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < NV; i++) begin
      reg_we_i         = VECS[i].we;
      reg_addr_i       = VECS[i].addr;
      reg_wdata_i      = VECS[i].wdata;
      cfg_pkt_i        = VECS[i].pkt;
      cfg_rhb_i        = VECS[i].prhb;
      cfg_gap_i        = VECS[i].pgap;
      bus_reset_done_i = VECS[i].rdone;
      @(negedge clk_i);
      chk($sformatf("R2-vec%0d gap", i), gap_count_o, VECS[i].egap);
      chk($sformatf("R5-vec%0d rhb", i), root_holdoff_o, VECS[i].erhb);
      chk($sformatf("R3-vec%0d long", i), long_reset_req_o, VECS[i].elong);
      chk($sformatf("R4-vec%0d short", i), short_reset_req_o, VECS[i].eshort);
      reg_we_i = 1'b0; cfg_pkt_i = 1'b0; bus_reset_done_i = 1'b0;
    end
    // readback: reg5 keeps 0xA4, bit1 cleared; reg1 = {rhb,0,gap}
    reg_addr_i = 4'd5; #1;
    chk("R4 reg5 readback", reg_rdata_o, 8'hA4);
    reg_addr_i = 4'd1; #1;
    chk("R2 reg1 readback", reg_rdata_o, 8'h3F);
    // long-reset bit reads 0 after write with rhb set
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 4'd1; reg_wdata_i = 8'hC9;
    @(negedge clk_i);
    reg_we_i = 1'b0; #1;
    chk("R3 reg1 ibr reads 0", reg_rdata_o, 8'h89);
    chk("R3 strobe", long_reset_req_o, 1);
    @(negedge clk_i);
    chk("R3 one cycle", long_reset_req_o, 0);
    // reg5 write without bit1: no strobe, value kept
    reg_we_i = 1'b1; reg_addr_i = 4'd5; reg_wdata_i = 8'h51;
    @(negedge clk_i);
    reg_we_i = 1'b0; #1;
    chk("R4 no strobe", short_reset_req_o, 0);
    chk("R4 reg5 kept", reg_rdata_o, 8'h51);
    // asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0; #2;
    check_reset_state();
    @(negedge clk_i);
    rst_ni = 1'b1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule